// File: doc/BRIEF.md
# Windowed Service-Key Watchdog

This block is a watchdog timer. Once software enables it, it asks for a system reset unless the service register receives a two-byte key before the selected period runs out. A control register holds four settings. A 3-bit rate code picks the period, and code zero turns the timer off. A window flag makes servicing legal only in the final quarter of the period. A freeze flag stops the count while a debug session is active. A mask flag protects the rate and window fields during a write.

Outside a special (test) mode, the rate and window fields accept exactly one write. The freeze flag can only be set in that case. Software services the timer by writing the arm byte 0x55 one or more times and then the fire byte 0xAA. Any other byte, or a fire byte with no arm byte before it, is a fault. Every fault produces a one-cycle reset request.

Both registers share one byte-wide write port, and a select line picks between them. The host supplies the special-mode and debug-active levels as inputs.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, the rate code, window flag, freeze flag, write-once record and arm state are all zero, and `rst_req` is low.
- R2: A control write (`wr_sel`=0) uses these fields: bits [2:0] rate code, bit 5 mask, bit 6 window enable, bit 7 freeze in debug. While the rate code is zero, the timer stays idle, service writes have no effect, and `rst_req` never rises.
- R3: For a rate code c from 1 to 7, the period P is 2^(12+2c-SCALE_SHIFT) cycles. Suppose a restart takes effect at clock edge k and no other event follows. Then `rst_req` is high for exactly the one cycle after edge k+P, and the count starts over from zero.
- R4: In normal mode (window flag 0), the byte 0x55 followed by 0xAA, both written to the service register (`wr_sel`=1), restarts the count at any point in the period. The byte 0x55 may be repeated before the 0xAA.
- R5: A service write of any byte other than 0x55 or 0xAA, or of 0xAA with no armed 0x55, raises `rst_req` in the next cycle. It also restarts the count and clears the arm state.
- R6: In window mode, a service write while the count is below 3P/4 raises `rst_req` in the next cycle. In the final quarter, the key sequence works as in R4. After a restart, the next service write is early again.
- R7: Outside special mode, only the first control write with mask 0 changes the rate code and window flag, even when it writes zeros. In special mode, they can be rewritten at any time.
- R8: A control write with bit 5 set leaves the rate code and window flag unchanged, and it does not use up the single write.
- R9: Outside special mode, a control write can set the freeze flag but cannot clear it. In special mode, the flag takes the written value.
- R10: The count restarts from zero when a control write loads a nonzero rate code, or when it changes the freeze flag from 0 to 1.
- R11: While the freeze flag is 1 and `debug_active` is high, the count holds its value. While the freeze flag is 0, the count keeps running during debug.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the service register |
| wr_data | input | 8 | Write data |
| special_mode | input | 1 | Lifts the write-once and set-only rules when high |
| debug_active | input | 1 | Debug session active |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Every fault is registered, so `rst_req` rises in the cycle after the write or terminal count that caused it. A time-out follows a restart at edge k on edge k+P. The bench drives inputs and reads `rst_req` on falling edges, half a cycle after each rising edge. At each falling edge, it compares the output with a behavioural model that advanced on the same rising edge. Because of this, every result is checked in the exact cycle it is due, never a cycle early or late. Pulse counts over fixed idle stretches then confirm the period, the write-once and mask rules, the freeze behaviour, and that a disabled timer stays silent.

// File: rtl/svc_watchdog.sv
module svc_watchdog #(
  parameter int         SCALE_SHIFT = 10,
  parameter logic [7:0] KEY_ARM     = 8'h55,
  parameter logic [7:0] KEY_FIRE    = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       special_mode,
  input  logic       debug_active,
  output logic       rst_req
);

  localparam int CW = 26 - SCALE_SHIFT;

  logic [2:0]    rate;
  logic          win_en, frz, once_used, armed;
  logic [CW-1:0] cnt;
  logic [CW:0]   per;
  int            sh;

  always_comb begin
    sh  = (rate == 3'd0) ? 0 : 12 + 2 * int'(rate) - SCALE_SHIFT;
    per = {{CW{1'b0}}, 1'b1} << sh;
  end

  wire [CW-1:0] term   = CW'(per - 1'b1);
  wire [CW-1:0] win_lo = CW'(per - (per >> 2));

  wire enabled  = rate != 3'd0;
  wire running  = enabled && !(frz && debug_active);
  wire ctl_wr   = wr_en && !wr_sel;
  wire svc_wr   = wr_en && wr_sel && enabled;
  wire ctl_take = ctl_wr && !wr_data[5] && (special_mode || !once_used);
  wire frz_next = special_mode ? wr_data[7] : (frz | wr_data[7]);

  wire ctl_restart = ctl_wr && ((ctl_take && wr_data[2:0] != 3'd0) || (!frz && frz_next));
  wire early       = win_en && (cnt < win_lo);
  wire key_ok      = (wr_data == KEY_FIRE) && armed;
  wire svc_restart = svc_wr && !early && key_ok;
  wire svc_fault   = svc_wr && (early || !(wr_data == KEY_ARM || key_ok));
  wire tmo         = running && (cnt == term) && !ctl_restart && !svc_restart;
  wire fault       = svc_fault || tmo;

  wire [2:0] rate_n = ctl_take ? wr_data[2:0] : rate;

  logic unused_bits;
  assign unused_bits = ^wr_data[4:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate      <= '0;
      win_en    <= 1'b0;
      frz       <= 1'b0;
      once_used <= 1'b0;
      armed     <= 1'b0;
      cnt       <= '0;
      rst_req   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        if (ctl_take) begin
          rate   <= wr_data[2:0];
          win_en <= wr_data[6];
          if (!special_mode) once_used <= 1'b1;
        end
        frz <= frz_next;
      end
      if (fault || svc_restart) armed <= 1'b0;
      else if (svc_wr && wr_data == KEY_ARM) armed <= 1'b1;
      if (fault || ctl_restart || svc_restart || rate_n == 3'd0) cnt <= '0;
      else if (running) cnt <= cnt + 1'b1;
      rst_req <= fault;
    end
  end

  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> !rst_req);

  a_r5_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && enabled && wr_data != KEY_ARM && wr_data != KEY_FIRE) |=> rst_req);

  a_r6_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && enabled && win_en && cnt < win_lo) |=> rst_req);

  a_r7_write_once: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && once_used) |=> ($stable(rate) && $stable(win_en)));

  a_r9_freeze_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && frz) |=> frz);

  a_r11_debug_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && debug_active && !wr_en) |=> $stable(cnt));

endmodule

// File: tb/svc_watchdog_test.sv
`timescale 1ns/1ps
module svc_watchdog_test;
  localparam int SH = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       special_mode = 1'b0;
  logic       debug_active = 1'b0;
  logic       rst_req;

  svc_watchdog #(.SCALE_SHIFT(SH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .special_mode(special_mode), .debug_active(debug_active), .rst_req(rst_req)
  );

  always #2.5 clk = ~clk;

  int vecs = 0, fails = 0, pulses = 0;
  string cur_req = "R1";

  int m_rate = 0, m_win = 0, m_frz = 0, m_once = 0, m_arm = 0, m_cnt = 0, m_rst = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rate = 0; m_win = 0; m_frz = 0; m_once = 0; m_arm = 0; m_cnt = 0; m_rst = 0;
    end else begin
      int per, nrate, nwin, nfrz, flt, rs, run;
      per   = (m_rate == 0) ? 0 : (1 << (12 + 2 * m_rate - SH));
      run   = (m_rate != 0 && !(m_frz == 1 && debug_active)) ? 1 : 0;
      flt = 0; rs = 0; nrate = m_rate; nwin = m_win; nfrz = m_frz;
      if (wr_en && !wr_sel) begin
        if (!wr_data[5] && (special_mode || m_once == 0)) begin
          nrate = int'(wr_data[2:0]);
          nwin  = int'(wr_data[6]);
          if (!special_mode) m_once = 1;
          if (nrate != 0) rs = 1;
        end
        if (special_mode) nfrz = int'(wr_data[7]);
        else if (wr_data[7]) nfrz = 1;
        if (m_frz == 0 && nfrz == 1) rs = 1;
      end
      if (wr_en && wr_sel && m_rate != 0) begin
        if (m_win == 1 && m_cnt * 4 < per * 3) flt = 1;
        else if (wr_data == 8'h55) m_arm = 1;
        else if (wr_data == 8'hAA && m_arm == 1) begin rs = 1; m_arm = 0; end
        else flt = 1;
      end
      if (run == 1 && m_cnt == per - 1 && rs == 0) flt = 1;
      if (flt == 1) m_arm = 0;
      m_rate = nrate; m_win = nwin; m_frz = nfrz;
      if (flt == 1 || rs == 1 || nrate == 0) m_cnt = 0;
      else if (run == 1) m_cnt = m_cnt + 1;
      m_rst = flt;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    vecs++;
    if (rst_req !== m_rst[0]) begin
      fails++;
      $display("FAIL %s: rst_req=%b expected %0d at %0t", cur_req, rst_req, m_rst, $time);
    end
    if (rst_req === 1'b1) pulses++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic ctl(logic [7:0] d);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic svc(logic [7:0] d);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic chk(string r, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; special_mode = 1'b0; debug_active = 1'b0;
    step(); step();
    rst_n = 1'b1;
    pulses = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    cur_req = "R1";
    do_reset();
    chk("R1", int'(rst_req), 0);
    idle(300);
    chk("R1", pulses, 0);

    cur_req = "R8";
    ctl(8'h23);
    pulses = 0; idle(64);
    chk("R8", pulses, 0);
    cur_req = "R3";
    ctl(8'h01);
    idle(15);
    chk("R3", int'(rst_req), 0);
    step();
    chk("R3", int'(rst_req), 1);
    step();
    chk("R3", int'(rst_req), 0);
    cur_req = "R7";
    ctl(8'h02);
    pulses = 0; idle(64);
    chk("R7", pulses, 4);

    cur_req = "R2";
    do_reset();
    ctl(8'h00);
    ctl(8'h01);
    svc(8'h12);
    pulses = 0; idle(200);
    chk("R2", pulses, 0);

    cur_req = "R4";
    do_reset();
    ctl(8'h01);
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      idle(8); svc(8'h55); svc(8'h55); svc(8'hAA);
    end
    chk("R4", pulses, 0);
    cur_req = "R5";
    pulses = 0; svc(8'hAA);
    chk("R5", pulses, 1);
    pulses = 0; svc(8'h12);
    chk("R5", pulses, 1);
    pulses = 0; svc(8'h55); svc(8'h3C);
    chk("R5", pulses, 1);

    cur_req = "R6";
    do_reset();
    special_mode = 1'b1;
    ctl(8'h41);
    pulses = 0; svc(8'h55);
    chk("R6", pulses, 1);
    idle(12);
    pulses = 0; svc(8'h55); svc(8'h55); svc(8'hAA);
    chk("R6", pulses, 0);
    pulses = 0; svc(8'h55);
    chk("R6", pulses, 1);
    cur_req = "R7";
    ctl(8'h02);
    pulses = 0; idle(64);
    chk("R7", pulses, 1);

    cur_req = "R10";
    do_reset();
    special_mode = 1'b1;
    ctl(8'h01);
    idle(10);
    ctl(8'h01);
    pulses = 0; idle(15);
    chk("R10", pulses, 0);
    step();
    chk("R10", pulses, 1);

    cur_req = "R11";
    do_reset();
    ctl(8'h01);
    idle(5);
    ctl(8'hA0);
    debug_active = 1'b1;
    pulses = 0; idle(100);
    chk("R11", pulses, 0);
    cur_req = "R9";
    ctl(8'h20);
    pulses = 0; idle(100);
    chk("R9", pulses, 0);
    special_mode = 1'b1;
    ctl(8'h20);
    cur_req = "R11";
    pulses = 0; idle(64);
    chk("R11", pulses, 4);
    debug_active = 1'b0;
    idle(5);

    summary();
  end
endmodule